// File: doc/BRIEF.md
# Request-Paced Byte Sender

This block hands bytes from a local producer to an outside consumer, one byte per consumer request. The consumer raises its request line to ask for data. The sender synchronizes that line into its own clock domain and treats a low-to-high change as one new request. It then enters a prepare phase. In that phase it drops its valid flag and asks the local producer for a byte through a valid/ready pair. When a byte is accepted, the sender places it on the output bus and raises the valid flag on the same clock edge.

Once a byte has gone out, it stays on the output bus with the valid flag high. It remains there for as long as the consumer takes to ask again. A request line that stays high is counted once and does not send a second byte. The consumer therefore sets the pace of the stream, and it can stall the flow at any time by not raising its request again.

Top module: `byte_push_sender`

## Requirements
- R1: After reset, `out_data` is 0, `out_valid` is low and `src_ready` is low. The block then waits for a request.
- R2: A request is a low-to-high change of `req_in` after it passes through `SYNC_STAGES` flops (default 2). `src_ready` first reads high after the (`SYNC_STAGES`+1)-th rising clock edge following the rise of `req_in`, and not before that edge.
- R3: During the prepare phase (`src_ready` high), `out_valid` is low and `out_data` keeps the previous byte.
- R4: `src_ready` stays high until `src_valid` is sampled high. Outside the prepare phase, `src_valid` and `src_data` have no effect on `out_data`.
- R5: On the clock edge where `src_valid` and `src_ready` are both high, `out_data` takes `src_data`, `out_valid` goes high and `src_ready` goes low, all on that same edge.
- R6: Once a byte has been sent, `out_data` and `out_valid` stay unchanged until the next request. This holds however long `req_in` stays low.
- R7: If `req_in` stays high after a byte has been sent, no further byte is fetched or sent.
- R8: The data path is `W` bits wide, 8 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Consumer request, asynchronous to clk |
| src_data | input | W | Byte offered by the local producer |
| src_valid | input | 1 | Local producer has a byte on `src_data` |
| src_ready | output | 1 | Sender is in the prepare phase and will take a byte |
| out_data | output | W | Byte presented to the consumer |
| out_valid | output | 1 | `out_data` holds a fresh byte |

## Verification
The bench targets the exact cycle in which a request reaches the prepare phase. A synchronizer that is one stage too short or too long shows up as `src_ready` rising a cycle early or late. It also checks that `out_valid` falls while a byte is being fetched; a design that left it high would mark a stale byte as fresh. A request held high while the producer keeps offering bytes exposes a level-sensitive design, which would send those bytes again and again. Producer delays of zero to several cycles, a zero byte loaded over all-ones, and a mid-run reset cover the load path and the return to the reset values.

// File: rtl/bps_pkg.sv
package bps_pkg;
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_PREP = 1'b1
    } bps_state_e;
endpackage

// File: rtl/bps_req_sync.sv
// Brings the consumer request into the clock domain and flags its rising edge.
module bps_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic req_rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], req_async};
        prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign req_rise = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/bps_fsm.sv
// Wait / prepare sequencer with a registered output byte and valid flag.
module bps_fsm
    import bps_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_rise,
    input  logic [W-1:0] src_data,
    input  logic         src_valid,
    output logic         src_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid
);
    typedef struct packed {
        bps_state_e   st;
        logic [W-1:0] data;
        logic         vld;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_WAIT: begin
                if (req_rise) begin
                    r_d.st  = ST_PREP;
                    r_d.vld = 1'b0;
                end
            end
            ST_PREP: begin
                if (src_valid) begin
                    r_d.st   = ST_WAIT;
                    r_d.data = src_data;
                    r_d.vld  = 1'b1;
                end
            end
            default: r_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_WAIT, data: '0, vld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign src_ready = (r_q.st == ST_PREP);
    assign out_data  = r_q.data;
    assign out_valid = r_q.vld;
endmodule

// File: rtl/byte_push_sender.sv
module byte_push_sender #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_in,
    input  logic [W-1:0] src_data,
    input  logic         src_valid,
    output logic         src_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid
);
    logic req_rise;

    bps_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req_in),
        .req_rise  (req_rise)
    );

    bps_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rise  (req_rise),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .out_data  (out_data),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/byte_push_sender_chk.sv
module byte_push_sender_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_rise,
    input logic [W-1:0] src_data,
    input logic         src_valid,
    input logic         src_ready,
    input logic [W-1:0] out_data,
    input logic         out_valid
);
    // R2: the prepare phase starts only after a recognised request edge
    assert_ready_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_ready) |-> $past(req_rise));

    // R3: no valid flag while a byte is being fetched
    assert_no_valid_in_prep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !out_valid);

    // R3: the old byte stays put through the prepare phase
    assert_prep_holds_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && $past(src_ready)) |-> $stable(out_data));

    // R5: an accepted byte appears with valid on the next cycle
    assert_load_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && src_valid) |=> (out_valid && !src_ready && out_data == $past(src_data)));

    // R6: a sent byte does not change while it is marked valid
    assert_hold_while_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(out_data));
endmodule

bind byte_push_sender byte_push_sender_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rise  (req_rise),
    .src_data  (src_data),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/byte_push_sender_tb.sv
module byte_push_sender_tb;
    localparam int W = 8;
    localparam int NV = 6;
    // each entry: {byte to send, producer delay in cycles}
    localparam logic [15:0] VEC [0:NV-1] = '{
        16'hA5_00, 16'h3C_01, 16'hFF_03, 16'h00_07, 16'h81_00, 16'h5A_02
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_in = 1'b0;
    logic [W-1:0] src_data = '0;
    logic         src_valid = 1'b0;
    logic         src_ready;
    logic [W-1:0] out_data;
    logic         out_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    byte_push_sender #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] prev_byte;
        logic         prev_vld;
        prev_byte = '0;
        prev_vld  = 1'b0;

        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 out_data after reset", out_data, 0);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 src_ready after reset", src_ready, 0);
        check("R8 data width", $bits(out_data), 8);

        // R4: producer offers a byte before any request; nothing changes
        src_valid = 1'b1;
        src_data  = 8'hEE;
        repeat (4) tick();
        check("R4 ignored before request data", out_data, 0);
        check("R4 ignored before request ready", src_ready, 0);
        src_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] b;
            int           dly;
            b   = VEC[i][15:8];
            dly = int'(VEC[i][7:0]);

            req_in = 1'b0;
            repeat (3) tick();
            if (prev_vld) begin
                check("R6 held data while idle", out_data, prev_byte);
                check("R6 held valid while idle", out_valid, 1);
            end

            req_in = 1'b1;
            tick();
            tick();
            check("R2 ready not yet", src_ready, 0);
            check("R2 valid unchanged before edge", out_valid, prev_vld);
            tick();
            check("R2 ready after sync", src_ready, 1);
            check("R3 valid low in prepare", out_valid, 0);
            check("R3 old data in prepare", out_data, prev_byte);

            for (int k = 0; k < dly; k++) begin
                tick();
                check("R4 ready held until valid", src_ready, 1);
                check("R3 valid still low", out_valid, 0);
            end

            src_valid = 1'b1;
            src_data  = b;
            tick();
            check("R5 byte loaded", out_data, b);
            check("R5 valid raised", out_valid, 1);
            check("R5 ready dropped", src_ready, 0);
            src_valid = 1'b0;
            src_data  = 8'h00;
            prev_byte = b;
            prev_vld  = 1'b1;
        end

        // R7: request stays high, producer keeps offering
        src_valid = 1'b1;
        src_data  = 8'h77;
        for (int k = 0; k < 8; k++) begin
            tick();
            check("R7 no refetch ready", src_ready, 0);
            check("R7 no resend data", out_data, prev_byte);
        end
        check("R7 valid kept", out_valid, 1);
        src_valid = 1'b0;

        // R6: long idle with request low
        req_in = 1'b0;
        repeat (40) tick();
        check("R6 long hold data", out_data, prev_byte);
        check("R6 long hold valid", out_valid, 1);

        // R1: reset in mid run
        rst_n = 1'b0;
        tick();
        check("R1 mid-run reset data", out_data, 0);
        check("R1 mid-run reset valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (5) tick();
        check("R1 waits after reset", src_ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule